// File: doc/BRIEF.md
# Tensor-Scalar Instruction Field Validator

The block inspects one 64-byte instruction word for a multi-scalar tensor-scalar operation and reports whether every field obeys its encoding rules. It pulls the opcode, the source and destination 4-D access patterns, the data-type codes, the channel count, the ALU op, the sub-dimension code, the operand-order code and the reserved bytes out of the word. Every rule has its own comparator. The results are registered, so a verdict appears one cycle after a word is presented.

Byte 0 of the word sits in bits 7:0, and multi-byte fields are little-endian. A 4-D pattern holds three things: a 4-byte start address at pattern offset 0, four signed 16-bit steps at offsets 4..11, and four unsigned 16-bit counts at offsets 12..19. Count k sits at offset 12+2k, and count 3 is the outer dimension W. The source pattern starts at byte 12 and the destination pattern at byte 44. Start addresses, steps and the event bytes 4..11 are carried but not checked.

The word is in bitvector mode when its opcode is 0x5F. Every other opcode, legal or not, is judged by the arith rules.

Top module: `tsv_validator`

## Requirements
- R1: When `inst_vld_i` is high at a rising edge, `res_vld_o` is high for the following cycle, and `ok_o` and `fault_o` take that word's verdict. Without `inst_vld_i`, `res_vld_o` is low and `ok_o`/`fault_o` keep their values. After reset all three are zero.
- R2: Byte 0 must be 0x4F (arith) or 0x5F (bitvector). Any other value, including 0x87, 0x88 and 0x43, sets fault bit 0.
- R3: The source W count (bytes 30..31) must lie in 1..8. Otherwise fault bit 1 is set.
- R4: The sub-dimension byte 37 must equal 0x04. Otherwise fault bit 2 is set.
- R5: The operand-order byte 38 must be 0 or 3. The values 1, 2 and any other value set fault bit 3.
- R6: Byte 35 and bytes 39..43 must all be zero. Otherwise fault bit 4 is set.
- R7: The op byte 36 must be below 0x20 and must not be 0x07, 0x1A or 0x1B. In arith mode it must also belong to {0x00-0x06, 0x10-0x19}. In bitvector mode it must also belong to {0x00, 0x08-0x0F, 0x1C}. A violation sets fault bit 5.
- R8: Fault bit 6 is set when a data-type rule fails. The input type is byte 32 and the output type is byte 33. In arith mode the input type must lie in {0x2-0xA, 0xD-0xF}, so 0xB is illegal. The output type must lie in the same set or be 0xB. In bitvector mode the input must equal the output, and the input must be one of 0x3, 0x5, 0x8 or 0x9.
- R9: The active channel count (byte 34) must lie in 1..128. Otherwise fault bit 7 is set.
- R10: The product of the four source counts must equal the product of the four destination counts. Otherwise fault bit 8 is set.
- R11: `ok_o` is high exactly when all nine fault bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inst_i | input | 512 | Instruction word, byte 0 in bits 7:0 |
| inst_vld_i | input | 1 | Word on `inst_i` is to be checked |
| res_vld_o | output | 1 | Verdict registered in the previous cycle |
| ok_o | output | 1 | Word obeys every rule |
| fault_o | output | 9 | One bit per failed rule (bit numbers as in R2..R10) |

## Verification
The bench starts from a legal arith word and a legal bitvector word, each with nonzero filler in the unchecked bytes. It then mutates one field at a time, so each fault bit is shown to respond to its own rule and to no other. The values just inside and just outside each range are applied: W of 0, 8 and 9, channel counts of 0, 128 and 129, and operand-order codes 0 through 3. These separate off-by-one decoding from correct bounds. The same op and type codes are replayed under both opcodes to show that the allowed sets switch with the mode. A word with several broken fields checks that faults combine. A final word presented without its strobe checks that the held verdict does not change.

// File: rtl/tsv_pkg.sv
package tsv_pkg;
  localparam int INST_BYTES = 64;
  localparam int INST_W     = 8 * INST_BYTES;
  localparam int CNT_N      = 4;
  localparam int CNT_W      = 16;
  localparam int VOL_W      = CNT_N * CNT_W;
  localparam int PAT_CNT    = 12;   // count field offset inside a pattern
  localparam int RSV_N      = 6;    // reserved bytes total

  localparam int OFF_OPC  = 0;
  localparam int OFF_SRC  = 12;
  localparam int OFF_IDT  = 32;
  localparam int OFF_ODT  = 33;
  localparam int OFF_CH   = 34;
  localparam int OFF_RSV0 = 35;
  localparam int OFF_OP   = 36;
  localparam int OFF_DIM  = 37;
  localparam int OFF_REV  = 38;
  localparam int OFF_RSV1 = 39;
  localparam int OFF_DST  = 44;

  localparam logic [7:0] OPC_ARITH = 8'h4F;
  localparam logic [7:0] OPC_BITV  = 8'h5F;
  localparam logic [7:0] DIM_XYZ   = 8'h04;
  localparam logic [7:0] REV_NONE  = 8'h00;
  localparam logic [7:0] REV_BOTH  = 8'h03;
  localparam logic [7:0] DT_FP32R  = 8'h0B;

  localparam int F_OPC = 0;
  localparam int F_W   = 1;
  localparam int F_DIM = 2;
  localparam int F_REV = 3;
  localparam int F_RSV = 4;
  localparam int F_OP  = 5;
  localparam int F_DT  = 6;
  localparam int F_CH  = 7;
  localparam int F_VOL = 8;
  localparam int N_FAULT = 9;

  typedef logic [CNT_N-1:0][CNT_W-1:0] cnt_vec_t;

  typedef struct packed {
    logic [7:0]       opc;
    cnt_vec_t         src_cnt;
    cnt_vec_t         dst_cnt;
    logic [7:0]       idt;
    logic [7:0]       odt;
    logic [7:0]       chan;
    logic [7:0]       op;
    logic [7:0]       dim;
    logic [7:0]       rev;
    logic [RSV_N-1:0][7:0] rsv;
  } fields_t;
endpackage

// File: rtl/tsv_field_unpack.sv
module tsv_field_unpack
  import tsv_pkg::*;
(
  input  logic [INST_W-1:0] inst_i,
  output fields_t           fld_o
);
  localparam int RSV1_N = RSV_N - 1;

  always_comb begin
    fld_o.opc  = inst_i[8*OFF_OPC +: 8];
    fld_o.idt  = inst_i[8*OFF_IDT +: 8];
    fld_o.odt  = inst_i[8*OFF_ODT +: 8];
    fld_o.chan = inst_i[8*OFF_CH  +: 8];
    fld_o.op   = inst_i[8*OFF_OP  +: 8];
    fld_o.dim  = inst_i[8*OFF_DIM +: 8];
    fld_o.rev  = inst_i[8*OFF_REV +: 8];
    fld_o.rsv[0] = inst_i[8*OFF_RSV0 +: 8];
    fld_o.src_cnt = '0;
    fld_o.dst_cnt = '0;
    for (int r = 0; r < RSV1_N; r++) begin
      fld_o.rsv[r+1] = inst_i[8*(OFF_RSV1+r) +: 8];
    end
    for (int k = 0; k < CNT_N; k++) begin
      fld_o.src_cnt[k] = inst_i[8*(OFF_SRC+PAT_CNT+2*k) +: CNT_W];
      fld_o.dst_cnt[k] = inst_i[8*(OFF_DST+PAT_CNT+2*k) +: CNT_W];
    end
  end
endmodule

// File: rtl/tsv_pattern_volume.sv
module tsv_pattern_volume
  import tsv_pkg::*;
(
  input  cnt_vec_t         cnt_i,
  output logic [VOL_W-1:0] vol_o
);
  logic [VOL_W-1:0] part [CNT_N+1];

  assign part[0] = VOL_W'(1);

  for (genvar k = 0; k < CNT_N; k++) begin : g_mul
    assign part[k+1] = part[k] * VOL_W'(cnt_i[k]);
  end

  assign vol_o = part[CNT_N];
endmodule

// File: rtl/tsv_rule_check.sv
module tsv_rule_check
  import tsv_pkg::*;
#(
  parameter int          W_MAX      = 8,
  parameter int          CH_MAX     = 128,
  parameter logic [31:0] ARITH_OPS  = 32'h03FF_007F,
  parameter logic [31:0] BITV_OPS   = 32'h1000_FF01,
  parameter logic [15:0] IN_DT_OK   = 16'hE7FC,
  parameter logic [15:0] OUT_DT_OK  = 16'hEFFC,
  parameter logic [15:0] BITV_DT_OK = 16'h0328
) (
  input  fields_t            fld_i,
  input  logic [VOL_W-1:0]   src_vol_i,
  input  logic [VOL_W-1:0]   dst_vol_i,
  output logic [N_FAULT-1:0] fault_o
);
  localparam int OP_SPAN = 32;
  localparam int DT_SPAN = 16;

  logic bitv_mode;
  logic op_in_range, op_banned, op_in_set;
  logic idt_in_range, odt_in_range, arith_dt_ok, bitv_dt_ok;
  logic [15:0] w_cnt;

  assign bitv_mode = (fld_i.opc == OPC_BITV);
  assign w_cnt     = fld_i.src_cnt[CNT_N-1];

  assign op_in_range = (int'(fld_i.op) < OP_SPAN);
  assign op_banned   = (fld_i.op == 8'h07) || (fld_i.op == 8'h1A) || (fld_i.op == 8'h1B);
  assign op_in_set   = bitv_mode ? BITV_OPS[fld_i.op[4:0]] : ARITH_OPS[fld_i.op[4:0]];

  assign idt_in_range = (int'(fld_i.idt) < DT_SPAN);
  assign odt_in_range = (int'(fld_i.odt) < DT_SPAN);
  assign arith_dt_ok  = idt_in_range && odt_in_range
                      && IN_DT_OK[fld_i.idt[3:0]] && (fld_i.idt != DT_FP32R)
                      && OUT_DT_OK[fld_i.odt[3:0]];
  assign bitv_dt_ok   = idt_in_range && (fld_i.idt == fld_i.odt)
                      && BITV_DT_OK[fld_i.idt[3:0]];

  always_comb begin
    fault_o        = '0;
    fault_o[F_OPC] = !((fld_i.opc == OPC_ARITH) || (fld_i.opc == OPC_BITV));
    fault_o[F_W]   = (w_cnt == 16'd0) || (int'(w_cnt) > W_MAX);
    fault_o[F_DIM] = (fld_i.dim != DIM_XYZ);
    fault_o[F_REV] = !((fld_i.rev == REV_NONE) || (fld_i.rev == REV_BOTH));
    fault_o[F_RSV] = |fld_i.rsv;
    fault_o[F_OP]  = !(op_in_range && !op_banned && op_in_set);
    fault_o[F_DT]  = bitv_mode ? !bitv_dt_ok : !arith_dt_ok;
    fault_o[F_CH]  = (fld_i.chan == 8'd0) || (int'(fld_i.chan) > CH_MAX);
    fault_o[F_VOL] = (src_vol_i != dst_vol_i);
  end

  // banned ops can never pass regardless of mask parameters
  always_comb begin
    if (op_banned) a_r7_banned_op : assert (fault_o[F_OP]);
  end
endmodule

// File: rtl/tsv_validator.sv
module tsv_validator
  import tsv_pkg::*;
#(
  parameter int          W_MAX      = 8,
  parameter int          CH_MAX     = 128,
  parameter logic [31:0] ARITH_OPS  = 32'h03FF_007F,
  parameter logic [31:0] BITV_OPS   = 32'h1000_FF01,
  parameter logic [15:0] IN_DT_OK   = 16'hE7FC,
  parameter logic [15:0] OUT_DT_OK  = 16'hEFFC,
  parameter logic [15:0] BITV_DT_OK = 16'h0328
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [INST_W-1:0]    inst_i,
  input  logic                 inst_vld_i,
  output logic                 res_vld_o,
  output logic                 ok_o,
  output logic [N_FAULT-1:0]   fault_o
);
  fields_t            fld;
  logic [VOL_W-1:0]   src_vol, dst_vol;
  logic [N_FAULT-1:0] fault_d, fault_q;
  logic               ok_q, res_vld_q;

  tsv_field_unpack u_unpack (
    .inst_i (inst_i),
    .fld_o  (fld)
  );

  tsv_pattern_volume u_src_vol (
    .cnt_i (fld.src_cnt),
    .vol_o (src_vol)
  );

  tsv_pattern_volume u_dst_vol (
    .cnt_i (fld.dst_cnt),
    .vol_o (dst_vol)
  );

  tsv_rule_check #(
    .W_MAX      (W_MAX),
    .CH_MAX     (CH_MAX),
    .ARITH_OPS  (ARITH_OPS),
    .BITV_OPS   (BITV_OPS),
    .IN_DT_OK   (IN_DT_OK),
    .OUT_DT_OK  (OUT_DT_OK),
    .BITV_DT_OK (BITV_DT_OK)
  ) u_rules (
    .fld_i     (fld),
    .src_vol_i (src_vol),
    .dst_vol_i (dst_vol),
    .fault_o   (fault_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q   <= '0;
      ok_q      <= 1'b0;
      res_vld_q <= 1'b0;
    end else begin
      res_vld_q <= inst_vld_i;
      if (inst_vld_i) begin
        fault_q <= fault_d;
        ok_q    <= ~|fault_d;
      end
    end
  end

  assign fault_o   = fault_q;
  assign ok_o      = ok_q;
  assign res_vld_o = res_vld_q;

  a_r1_result_strobe : assert property (@(posedge clk_i) disable iff (!rst_ni)
    inst_vld_i |=> res_vld_o);

  a_r1_verdict_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inst_vld_i |=> (!res_vld_o && $stable(fault_o) && $stable(ok_o)));

  a_r2_bad_opcode : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inst_vld_i && (inst_i[7:0] != OPC_ARITH) && (inst_i[7:0] != OPC_BITV))
    |=> (fault_o[F_OPC] && !ok_o));

  a_r4_subdim : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inst_vld_i && (inst_i[8*OFF_DIM +: 8] != DIM_XYZ)) |=> fault_o[F_DIM]);

  a_r9_no_channels : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inst_vld_i && (inst_i[8*OFF_CH +: 8] == 8'd0)) |=> fault_o[F_CH]);

  a_r11_ok_matches_mask : assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_o |-> (ok_o == (fault_o == '0)));
endmodule

// File: tb/tsv_validator_test.sv
module tsv_validator_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic         clk, rst_n, vld;
  logic [511:0] inst;
  logic         res_vld, ok;
  logic [8:0]   fault;

  int n_checks = 0;
  int n_fail   = 0;

  // instruction field values used by build()
  logic [7:0]        b_opc, b_idt, b_odt, b_ch, b_op, b_dim, b_rev;
  logic [3:0][15:0]  b_sc, b_dc;

  tsv_validator uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .inst_i     (inst),
    .inst_vld_i (vld),
    .res_vld_o  (res_vld),
    .ok_o       (ok),
    .fault_o    (fault)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [511:0] build();
    logic [511:0] w;
    w = '0;
    for (int b = 1; b < 12; b++) w[8*b +: 8] = 8'hA5;   // header tail and events filler
    w[8*12 +: 32] = 32'hDEAD_0010;                        // src start address
    w[8*44 +: 32] = 32'hBEEF_0200;                        // dst start address
    for (int k = 0; k < 4; k++) begin
      w[8*(16+2*k) +: 16] = 16'hFFF0 + 16'(k);            // src steps
      w[8*(48+2*k) +: 16] = 16'h0007;                     // dst steps
      w[8*(24+2*k) +: 16] = b_sc[k];
      w[8*(56+2*k) +: 16] = b_dc[k];
    end
    w[7:0]        = b_opc;
    w[8*32 +: 8]  = b_idt;
    w[8*33 +: 8]  = b_odt;
    w[8*34 +: 8]  = b_ch;
    w[8*36 +: 8]  = b_op;
    w[8*37 +: 8]  = b_dim;
    w[8*38 +: 8]  = b_rev;
    return w;
  endfunction

  task automatic base_arith();
    b_opc = 8'h4F; b_idt = 8'h0A; b_odt = 8'h0B; b_ch = 8'd64;
    b_op = 8'h01; b_dim = 8'h04; b_rev = 8'h00;
    b_sc = {16'd2, 16'd3, 16'd2, 16'd4};   // W,Z,Y,X -> 48
    b_dc = {16'd2, 16'd1, 16'd3, 16'd8};   // 48
  endtask

  task automatic base_bitv();
    base_arith();
    b_opc = 8'h5F; b_op = 8'h0D; b_idt = 8'h09; b_odt = 8'h09;
  endtask

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // present one word, sample the registered verdict one cycle later
  task automatic apply(logic [511:0] w, string req, logic [8:0] exp);
    @(negedge clk);
    inst = w; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    check(req, "res_vld", 32'(res_vld), 32'd1);
    check(req, "fault", 32'(fault), 32'(exp));
    check(req, "ok", 32'(ok), 32'(exp == 9'd0));
  endtask

  task automatic t_reset();
    check("R1", "reset res_vld", 32'(res_vld), 0);
    check("R1", "reset ok", 32'(ok), 0);
    check("R1", "reset fault", 32'(fault), 0);
  endtask

  task automatic t_legal();
    base_arith(); apply(build(), "R11", 9'h000);
    base_bitv();  apply(build(), "R11", 9'h000);
  endtask

  task automatic t_opcode();
    base_arith(); b_opc = 8'h87; apply(build(), "R2", 9'h001);
    base_arith(); b_opc = 8'h88; apply(build(), "R2", 9'h001);
    base_arith(); b_opc = 8'h43; apply(build(), "R2", 9'h001);
  endtask

  task automatic t_w();
    base_arith(); b_sc[3] = 16'd0; b_dc[3] = 16'd0; apply(build(), "R3", 9'h002);
    base_arith(); b_sc[3] = 16'd9; b_dc[3] = 16'd9; apply(build(), "R3", 9'h002);
    base_arith(); b_sc[3] = 16'd8; b_dc[3] = 16'd8; apply(build(), "R3", 9'h000);
    base_arith(); b_sc[3] = 16'd1; b_dc[3] = 16'd1; apply(build(), "R3", 9'h000);
  endtask

  task automatic t_dim_rev();
    base_arith(); b_dim = 8'h05; apply(build(), "R4", 9'h004);
    base_arith(); b_dim = 8'h03; apply(build(), "R4", 9'h004);
    base_arith(); b_rev = 8'h01; apply(build(), "R5", 9'h008);
    base_arith(); b_rev = 8'h02; apply(build(), "R5", 9'h008);
    base_arith(); b_rev = 8'h03; apply(build(), "R5", 9'h000);
  endtask

  task automatic t_reserved();
    logic [511:0] w;
    base_arith(); w = build(); w[8*35 +: 8] = 8'h01; apply(w, "R6", 9'h010);
    base_arith(); w = build(); w[8*43 +: 8] = 8'h80; apply(w, "R6", 9'h010);
    base_arith(); w = build(); w[8*40 +: 8] = 8'h10; apply(w, "R6", 9'h010);
  endtask

  task automatic t_ops();
    base_arith(); b_op = 8'h07; apply(build(), "R7", 9'h020);
    base_arith(); b_op = 8'h1A; apply(build(), "R7", 9'h020);
    base_arith(); b_op = 8'h0D; apply(build(), "R7", 9'h020);
    base_arith(); b_op = 8'h19; apply(build(), "R7", 9'h000);
    base_arith(); b_op = 8'h21; apply(build(), "R7", 9'h020);
    base_bitv();  b_op = 8'h01; apply(build(), "R7", 9'h020);
    base_bitv();  b_op = 8'h1B; apply(build(), "R7", 9'h020);
    base_bitv();  b_op = 8'h1C; apply(build(), "R7", 9'h000);
    base_bitv();  b_op = 8'h00; apply(build(), "R7", 9'h000);
  endtask

  task automatic t_dtypes();
    base_arith(); b_idt = 8'h0B; apply(build(), "R8", 9'h040);
    base_arith(); b_idt = 8'h02; b_odt = 8'h0F; apply(build(), "R8", 9'h000);
    base_arith(); b_idt = 8'h0C; apply(build(), "R8", 9'h040);
    base_arith(); b_odt = 8'h00; apply(build(), "R8", 9'h040);
    base_bitv();  b_idt = 8'h05; b_odt = 8'h05; apply(build(), "R8", 9'h000);
    base_bitv();  b_idt = 8'h09; b_odt = 8'h08; apply(build(), "R8", 9'h040);
    base_bitv();  b_idt = 8'h02; b_odt = 8'h02; apply(build(), "R8", 9'h040);
    base_bitv();  b_idt = 8'h0A; b_odt = 8'h0A; apply(build(), "R8", 9'h040);
  endtask

  task automatic t_channels();
    base_arith(); b_ch = 8'd0;   apply(build(), "R9", 9'h080);
    base_arith(); b_ch = 8'd129; apply(build(), "R9", 9'h080);
    base_arith(); b_ch = 8'd128; apply(build(), "R9", 9'h000);
    base_arith(); b_ch = 8'd1;   apply(build(), "R9", 9'h000);
  endtask

  task automatic t_volume();
    base_arith(); b_dc[0] = 16'd9; apply(build(), "R10", 9'h100);
    base_arith(); b_dc = {16'd1, 16'd1, 16'd1, 16'd48}; b_sc[3] = 16'd1;
    b_sc[0] = 16'd8; apply(build(), "R10", 9'h000);
    base_bitv(); b_sc = {16'd8, 16'd65535, 16'd65535, 16'd2};
    b_dc = {16'd8, 16'd65535, 16'd65535, 16'd2}; apply(build(), "R10", 9'h000);
    b_dc[1] = 16'd65534; apply(build(), "R10", 9'h100);
  endtask

  task automatic t_multi();
    base_arith(); b_opc = 8'h88; b_ch = 8'd0; b_dim = 8'h05; apply(build(), "R11", 9'h085);
  endtask

  task automatic t_hold();
    base_arith(); apply(build(), "R1", 9'h000);
    base_arith(); b_opc = 8'h00; b_ch = 8'd0;
    @(negedge clk); inst = build(); vld = 1'b0;
    @(negedge clk);
    check("R1", "hold res_vld", 32'(res_vld), 0);
    check("R1", "hold fault", 32'(fault), 0);
    check("R1", "hold ok", 32'(ok), 1);
  endtask

  initial begin
    rst_n = 1'b0; vld = 1'b0; inst = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_legal();
    t_opcode();
    t_w();
    t_dim_rev();
    t_reserved();
    t_ops();
    t_dtypes();
    t_channels();
    t_volume();
    t_multi();
    t_hold();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule